// File: doc/BRIEF.md
# Smart Card Character Transceiver with Automatic Retry

This block moves single characters over the one shared, open-drain data line between a host and a smart card. Both ends only ever pull the line low; an external resistor pulls it high. A character is a start bit (low), eight data bits and one parity bit, each lasting one elementary time unit (ETU). After the parity bit comes a guard period in which the receiving side may report a parity failure. It reports it by pulling the line low for one ETU. The transmitter watches for that pulse and, if it sees it, sends the identical character again, up to a set number of resends.

The block is half duplex. While it transmits, its receiver ignores the line. While it receives, a queued character waits. Static inputs select the bit order, the data inversion and the parity sense; together these give the direct or the inverse card convention. A further input selects the shortened guard period used by the mobile-handset variant. A clock-output mode field drives the card clock pin: stopped, free running, or held at a fixed level.

Timing comes from `baud_tick`, a single-cycle pulse that occurs `2**OVS_LOG2` times per ETU. One host byte can be held for transmission, and one received byte is held until it is read. Level flags report the state of both buffers and the errors seen.

Top module: `scard_xcvr`

## Requirements
- R1: After reset, `tx_empty`=1, `tx_done`=1, `rx_full`=0, all four error flags are 0, `io_drive_low`=0 and `card_clk`=0.
- R2: When `tx_en`=1, a write to an empty buffer sets `tx_empty`=0. On the next baud tick the frame starts and `tx_empty` returns to 1. The line then carries the start bit (low), the line bits L0..L7 and then the parity bit, each for `2**OVS_LOG2` ticks. With `cfg_msb_first`=0 and `cfg_invert`=0, Li equals data bit i. A 1 is a released (high) line.
- R3: With `cfg_msb_first`=1, Li is data bit 7-i. With `cfg_invert`=1, every Li is inverted. Setting both gives the inverse convention.
- R4: The parity bit is computed over L0..L7 as they appear on the line. With `cfg_odd_par`=0 the count of ones in L0..L7 plus parity is even; with `cfg_odd_par`=1 it is odd.
- R5: The transmitter samples the line 11 ETU after the frame start. A low level there sets `err_nack`. The identical frame is then sent again, starting 12 ETU after the previous start.
- R6: After `MAX_RETRY` resends that are all refused, no further frame is sent, `err_retry`=1 and `tx_done`=1.
- R7: After an accepted frame, `tx_done` becomes 1 at 12 ETU after the start when `cfg_gsm`=0, and at 11 ETU when `cfg_gsm`=1.
- R8: A received frame with correct parity is decoded with the same order, inversion and parity settings. It then appears on `rx_byte` with `rx_full`=1, and the block does not pull the line low. `rx_rd` clears `rx_full`.
- R9: A received frame with wrong parity sets `err_parity` and leaves `rx_full` unchanged. The block pulls the line low from 10.5 ETU to 11.5 ETU after the start edge.
- R10: A correct frame that arrives while `rx_full`=1 sets `err_overrun` and leaves `rx_byte` unchanged.
- R11: With `rx_en`=0 an incoming frame is ignored: no error pulse and no change to `rx_full`. With `tx_en`=0 a buffered byte is not sent. `flag_clr` clears the four error flags.
- R12: `card_clk` follows `cfg_clk_mode`. 00 holds it low. 01 toggles it every clock. 1x holds it at the level of bit 0 when `cfg_gsm`=1, and holds it low when `cfg_gsm`=0.
- R13: The block's own transmitted frames, including refused ones, never set `rx_full` or `err_parity`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | Pulse, 2**OVS_LOG2 per ETU |
| cfg_msb_first | input | 1 | 1: most significant data bit sent first |
| cfg_invert | input | 1 | 1: data bits inverted on the line |
| cfg_odd_par | input | 1 | 0: even parity, 1: odd parity |
| cfg_gsm | input | 1 | Shortened-guard variant select |
| cfg_clk_mode | input | 2 | Card clock output mode |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| tx_wr | input | 1 | Write strobe for tx_byte |
| tx_byte | input | 8 | Byte to send |
| rx_rd | input | 1 | Read strobe, clears rx_full |
| flag_clr | input | 1 | Clears the error flags |
| io_in | input | 1 | Sampled (already synchronous) level of the data line |
| io_drive_low | output | 1 | 1: pull the data line low |
| card_clk | output | 1 | Card clock |
| tx_empty | output | 1 | Transmit buffer free |
| tx_done | output | 1 | Transmitter idle after its last frame |
| rx_full | output | 1 | Received byte waiting |
| rx_byte | output | 8 | Last accepted byte |
| err_overrun | output | 1 | Frame lost because rx_full was set |
| err_parity | output | 1 | Received frame had wrong parity |
| err_nack | output | 1 | Error pulse seen after a sent frame |
| err_retry | output | 1 | Resend limit reached |

## Verification
The bench acts as the card. It decodes every frame the block sends and compares it with the line bits it builds from the requirement rules. This is done for direct, inverse and odd-parity settings, which tells bit order, inversion and parity sense apart. The card then answers with zero, one, and `MAX_RETRY`+1 error pulses; this separates a single resend from the limit and checks that a refused frame is repeated bit for bit. The card also sends good, bad-parity and back-to-back frames, which separates acceptance, error signalling and overrun. The clock output is compared with a model on every clock in each mode.

// File: rtl/scard_pkg.sv
// Shared helpers for the smart card transceiver.
// Assumes line position 0 is the first data bit after the start bit.
package scard_pkg;

    // Number of data bits in one character.
    localparam int DATA_BITS = 8;

    // Places data bits into line order, applying order and inversion.
    function automatic logic [7:0] to_line(input logic [7:0] d, input logic msb, input logic inv);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            r[i] = (msb ? d[7-i] : d[i]) ^ inv;
        end
        return r;
    endfunction

    // Recovers data bits from line order, undoing order and inversion.
    function automatic logic [7:0] from_line(input logic [7:0] l, input logic msb, input logic inv);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            r[msb ? 7-i : i] = l[i] ^ inv;
        end
        return r;
    endfunction

endpackage

// File: rtl/scard_tx.sv
// Transmit engine: holds one byte, sends it as a framed character,
// watches the guard period for an error pulse and resends up to MAX_RETRY times.
// Assumes baud_tick occurs 2**OVS_LOG2 times per ETU and io_in is synchronous.
module scard_tx
    import scard_pkg::*;
#(
    parameter int OVS_LOG2  = 2,
    parameter int MAX_RETRY = 3,
    localparam int RW       = $clog2(MAX_RETRY + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          en,
    input  logic          rx_busy,
    input  logic          msb_first,
    input  logic          invert,
    input  logic          odd_par,
    input  logic          gsm,
    input  logic          wr,
    input  logic [7:0]    wr_byte,
    input  logic          io_in,
    output logic          drive,
    output logic          empty,
    output logic          done,
    output logic          busy,
    output logic [RW-1:0] tries,
    output logic          ev_nack,
    output logic          ev_fail
);
    localparam int OVS       = 1 << OVS_LOG2;
    localparam int CW        = OVS_LOG2 + 4;
    localparam int SAMPLE_AT = 11 * OVS;
    localparam int END_AT    = 12 * OVS;

    logic [7:0]    hold;
    logic          full;
    logic [9:0]    frame;
    logic [CW-1:0] cnt;
    logic          nacked;
    logic [CW-1:0] cnt_nx;
    logic [3:0]    bidx;
    logic [7:0]    load_line;

    assign cnt_nx    = cnt + 1'b1;
    assign bidx      = cnt[CW-1:OVS_LOG2];
    assign load_line = to_line(hold, msb_first, invert);
    assign empty     = !full;

    // Line driver: pull low for every zero bit of the active frame.
    always_comb begin
        drive = 1'b0;
        if (busy && bidx < 4'd10) begin
            drive = !frame[bidx];
        end
    end

    // Buffer, frame sequencing, guard-time check and resend control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold    <= '0;
            full    <= 1'b0;
            frame   <= '1;
            cnt     <= '0;
            nacked  <= 1'b0;
            tries   <= '0;
            busy    <= 1'b0;
            done    <= 1'b1;
            ev_nack <= 1'b0;
            ev_fail <= 1'b0;
        end else begin
            ev_nack <= 1'b0;
            ev_fail <= 1'b0;
            if (wr && !full) begin
                hold <= wr_byte;
                full <= 1'b1;
            end
            if (!busy) begin
                if (tick && full && en && !rx_busy) begin
                    frame  <= {(^load_line) ^ odd_par, load_line, 1'b0};
                    full   <= 1'b0;
                    busy   <= 1'b1;
                    cnt    <= '0;
                    nacked <= 1'b0;
                    tries  <= '0;
                    done   <= 1'b0;
                end
            end else if (tick) begin
                cnt <= cnt_nx;
                if (cnt_nx == CW'(SAMPLE_AT)) begin
                    if (!io_in) begin
                        nacked  <= 1'b1;
                        ev_nack <= 1'b1;
                    end else if (gsm) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end
                if (cnt_nx == CW'(END_AT)) begin
                    if (nacked && tries != RW'(MAX_RETRY)) begin
                        tries  <= tries + 1'b1;
                        cnt    <= '0;
                        nacked <= 1'b0;
                    end else begin
                        busy    <= 1'b0;
                        done    <= 1'b1;
                        ev_fail <= nacked;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/scard_rx.sv
// Receive engine: detects a start edge, samples each bit in its middle,
// checks parity and pulls the line low in the guard time on a parity error.
// Assumes io_in is synchronous and the transmitter is idle while it runs.
module scard_rx
    import scard_pkg::*;
#(
    parameter int OVS_LOG2 = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       en,
    input  logic       tx_busy,
    input  logic       msb_first,
    input  logic       invert,
    input  logic       odd_par,
    input  logic       io_in,
    output logic       drive,
    output logic       busy,
    output logic       ev_good,
    output logic       ev_bad,
    output logic [7:0] data
);
    localparam int OVS    = 1 << OVS_LOG2;
    localparam int CW     = OVS_LOG2 + 4;
    localparam int HALF   = OVS / 2;
    localparam int END_AT = 12 * OVS;

    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nx;
    logic [3:0]    k;
    logic          mid;
    logic [7:0]    shreg;
    logic          bad;

    assign cnt_nx = cnt + 1'b1;
    assign k      = cnt_nx[CW-1:OVS_LOG2];
    assign mid    = cnt_nx[OVS_LOG2-1:0] == OVS_LOG2'(HALF);
    assign data   = from_line(shreg, msb_first, invert);

    // Start detection, mid-bit sampling, parity check and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            shreg   <= '0;
            bad     <= 1'b0;
            busy    <= 1'b0;
            drive   <= 1'b0;
            ev_good <= 1'b0;
            ev_bad  <= 1'b0;
        end else begin
            ev_good <= 1'b0;
            ev_bad  <= 1'b0;
            if (!busy) begin
                if (en && !tx_busy && !io_in) begin
                    busy <= 1'b1;
                    cnt  <= '0;
                    bad  <= 1'b0;
                end
            end else if (tick) begin
                cnt <= cnt_nx;
                if (mid) begin
                    if (k == 4'd0 && io_in) begin
                        busy <= 1'b0;
                    end else if (k >= 4'd1 && k <= 4'd8) begin
                        shreg[k[2:0] - 3'd1] <= io_in;
                    end else if (k == 4'd9) begin
                        if (((^shreg) ^ io_in) != odd_par) begin
                            bad    <= 1'b1;
                            ev_bad <= 1'b1;
                        end else begin
                            ev_good <= 1'b1;
                        end
                    end else if (k == 4'd10) begin
                        drive <= bad;
                    end else if (k == 4'd11) begin
                        drive <= 1'b0;
                    end
                end
                if (cnt_nx == CW'(END_AT)) begin
                    busy  <= 1'b0;
                    drive <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/scard_clkout.sv
// Card clock output: stopped, free running at half the system clock, or held.
// Assumes a held level is only meaningful in the shortened-guard variant.
module scard_clkout (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       gsm,
    input  logic [1:0] mode,
    output logic       card_clk
);
    // Select the next clock level from the mode field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            card_clk <= 1'b0;
        end else if (mode == 2'b01) begin
            card_clk <= !card_clk;
        end else if (gsm && mode[1]) begin
            card_clk <= mode[0];
        end else begin
            card_clk <= 1'b0;
        end
    end
endmodule

// File: rtl/scard_xcvr.sv
// Top level of the smart card character transceiver: joins the transmit
// and receive engines on one open-drain line and keeps the level flags.
// Assumes the line level on io_in is already synchronous to clk.
module scard_xcvr #(
    parameter int OVS_LOG2  = 2,
    parameter int MAX_RETRY = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic       cfg_msb_first,
    input  logic       cfg_invert,
    input  logic       cfg_odd_par,
    input  logic       cfg_gsm,
    input  logic [1:0] cfg_clk_mode,
    input  logic       tx_en,
    input  logic       rx_en,
    input  logic       tx_wr,
    input  logic [7:0] tx_byte,
    input  logic       rx_rd,
    input  logic       flag_clr,
    input  logic       io_in,
    output logic       io_drive_low,
    output logic       card_clk,
    output logic       tx_empty,
    output logic       tx_done,
    output logic       rx_full,
    output logic [7:0] rx_byte,
    output logic       err_overrun,
    output logic       err_parity,
    output logic       err_nack,
    output logic       err_retry
);
    localparam int RW = $clog2(MAX_RETRY + 1);

    logic          tx_drive, rx_drive;
    logic          tx_busy, rx_busy;
    logic [RW-1:0] tx_tries;
    logic          ev_nack, ev_fail, ev_good, ev_bad;
    logic [7:0]    rx_data;

    scard_tx #(.OVS_LOG2(OVS_LOG2), .MAX_RETRY(MAX_RETRY)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .en(tx_en), .rx_busy(rx_busy),
        .msb_first(cfg_msb_first), .invert(cfg_invert), .odd_par(cfg_odd_par),
        .gsm(cfg_gsm), .wr(tx_wr), .wr_byte(tx_byte), .io_in(io_in),
        .drive(tx_drive), .empty(tx_empty), .done(tx_done), .busy(tx_busy),
        .tries(tx_tries), .ev_nack(ev_nack), .ev_fail(ev_fail)
    );

    scard_rx #(.OVS_LOG2(OVS_LOG2)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .en(rx_en), .tx_busy(tx_busy),
        .msb_first(cfg_msb_first), .invert(cfg_invert), .odd_par(cfg_odd_par),
        .io_in(io_in), .drive(rx_drive), .busy(rx_busy),
        .ev_good(ev_good), .ev_bad(ev_bad), .data(rx_data)
    );

    scard_clkout u_clk (
        .clk(clk), .rst_n(rst_n), .gsm(cfg_gsm), .mode(cfg_clk_mode), .card_clk(card_clk)
    );

    assign io_drive_low = tx_drive | rx_drive;

    // Receive holding register and sticky error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_full     <= 1'b0;
            rx_byte     <= '0;
            err_overrun <= 1'b0;
            err_parity  <= 1'b0;
            err_nack    <= 1'b0;
            err_retry   <= 1'b0;
        end else begin
            if (flag_clr) begin
                err_overrun <= 1'b0;
                err_parity  <= 1'b0;
                err_nack    <= 1'b0;
                err_retry   <= 1'b0;
            end
            if (rx_rd) begin
                rx_full <= 1'b0;
            end
            if (ev_good) begin
                if (rx_full && !rx_rd) begin
                    err_overrun <= 1'b1;
                end else begin
                    rx_byte <= rx_data;
                    rx_full <= 1'b1;
                end
            end
            if (ev_bad)  err_parity <= 1'b1;
            if (ev_nack) err_nack   <= 1'b1;
            if (ev_fail) err_retry  <= 1'b1;
        end
    end
endmodule

// File: rtl/scard_xcvr_chk.sv
// Property checker for the smart card transceiver, bound to the top level.
// Assumes it sees the top-level ports plus the engine busy and retry signals.
module scard_xcvr_chk #(
    parameter int MAX_RETRY = 3,
    parameter int RW        = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    cfg_clk_mode,
    input logic          rx_en,
    input logic          io_drive_low,
    input logic          card_clk,
    input logic          tx_empty,
    input logic          tx_done,
    input logic          rx_full,
    input logic [7:0]    rx_byte,
    input logic          err_overrun,
    input logic          err_parity,
    input logic          err_retry,
    input logic          tx_busy,
    input logic          rx_busy,
    input logic [RW-1:0] tx_tries
);
    // R1: the state right after reset release.
    p_reset_state_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (tx_empty && tx_done && !rx_full && !io_drive_low && !err_retry));

    // R13: the two engines are never active together.
    p_half_duplex_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_busy && rx_busy));

    // R6: the resend count stays within its limit.
    p_retry_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_tries <= RW'(MAX_RETRY));

    // R9: a parity failure never delivers a byte.
    p_parity_no_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_parity) |-> !$rose(rx_full));

    // R10: an overrun leaves the held byte untouched.
    p_overrun_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_overrun) |-> $stable(rx_byte));

    // R11: a disabled, idle receiver stays idle.
    p_rx_disabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !rx_busy) |=> !rx_busy);

    // R12: mode 00 stops the card clock low.
    p_clk_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_clk_mode == 2'b00) |=> !card_clk);

    // R12: mode 01 toggles the card clock each cycle.
    p_clk_run_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_clk_mode == 2'b01) |=> (card_clk != $past(card_clk)));
endmodule

bind scard_xcvr scard_xcvr_chk #(.MAX_RETRY(MAX_RETRY), .RW(RW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_clk_mode(cfg_clk_mode), .rx_en(rx_en),
    .io_drive_low(io_drive_low), .card_clk(card_clk), .tx_empty(tx_empty),
    .tx_done(tx_done), .rx_full(rx_full), .rx_byte(rx_byte),
    .err_overrun(err_overrun), .err_parity(err_parity), .err_retry(err_retry),
    .tx_busy(tx_busy), .rx_busy(rx_busy), .tx_tries(tx_tries)
);

// File: tb/test_scard_xcvr.sv
// Bench for the smart card transceiver: the bench plays the card on the
// shared line, and a clock-output model is compared on every clock.
module test_scard_xcvr;
    localparam int OVS  = 4;
    localparam int MAXR = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0, baud_tick = 1'b0;
    logic       cfg_msb_first = 0, cfg_invert = 0, cfg_odd_par = 0, cfg_gsm = 0;
    logic [1:0] cfg_clk_mode = 2'b00;
    logic       tx_en = 0, rx_en = 0, tx_wr = 0, rx_rd = 0, flag_clr = 0;
    logic [7:0] tx_byte = '0;
    logic       card_drive = 1'b0;
    logic       dut_drive, card_clk, tx_empty, tx_done, rx_full;
    logic [7:0] rx_byte;
    logic       err_overrun, err_parity, err_nack, err_retry;
    wire        io_line = !(dut_drive | card_drive);

    int checks = 0, fails = 0;

    scard_xcvr #(.OVS_LOG2(2), .MAX_RETRY(MAXR)) i_scard_xcvr (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .cfg_msb_first(cfg_msb_first), .cfg_invert(cfg_invert), .cfg_odd_par(cfg_odd_par),
        .cfg_gsm(cfg_gsm), .cfg_clk_mode(cfg_clk_mode), .tx_en(tx_en), .rx_en(rx_en),
        .tx_wr(tx_wr), .tx_byte(tx_byte), .rx_rd(rx_rd), .flag_clr(flag_clr),
        .io_in(io_line), .io_drive_low(dut_drive), .card_clk(card_clk),
        .tx_empty(tx_empty), .tx_done(tx_done), .rx_full(rx_full), .rx_byte(rx_byte),
        .err_overrun(err_overrun), .err_parity(err_parity), .err_nack(err_nack),
        .err_retry(err_retry)
    );

    // Baud tick: one pulse every four clocks, driven on the falling edge.
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv      <= (tdiv + 1) % 4;
        baud_tick <= (tdiv == 3);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R12 reference model of the card clock, compared every clock.
    logic exp_clk = 1'b0;
    always @(posedge clk) begin
        if (!rst_n) exp_clk <= 1'b0;
        else if (cfg_clk_mode == 2'b01) exp_clk <= !exp_clk;
        else if (cfg_gsm && cfg_clk_mode[1]) exp_clk <= cfg_clk_mode[0];
        else exp_clk <= 1'b0;
    end
    always @(negedge clk) begin
        if (rst_n) chk(card_clk === exp_clk, "R12 card_clk", card_clk, exp_clk);
    end

    // Line bits L0..L7 and parity as stated in R2, R3 and R4.
    function automatic logic [8:0] exp_line(input logic [7:0] d, input bit msb, input bit inv, input bit odd);
        logic [8:0] r;
        for (int i = 0; i < 8; i++) r[i] = (msb ? d[7-i] : d[i]) ^ inv;
        r[8] = ($countones(r[7:0]) % 2 == 1) ^ odd;
        return r;
    endfunction

    task automatic wait_tick();
        do @(posedge clk); while (!baud_tick);
        @(negedge clk);
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk); tx_wr = 1'b1; tx_byte = b;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic pulse_rd();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    // Card receives one frame; optionally answers with an error pulse.
    task automatic card_take(input bit nack, output logic [8:0] bits, output bit d11, output bit d12);
        bits = '0; d11 = 1'b0; d12 = 1'b0;
        while (io_line !== 1'b0) @(negedge clk);
        for (int m = 1; m <= 12*OVS; m++) begin
            wait_tick();
            if ((m % OVS) == OVS/2 && m > OVS && m < 10*OVS) bits[m/OVS - 1] = io_line;
            if (nack && m == 10*OVS + OVS/2) card_drive = 1'b1;
            if (m == 11*OVS + OVS/2) card_drive = 1'b0;
            if (m == 11*OVS) d11 = tx_done;
            if (m == 12*OVS) d12 = tx_done;
        end
    endtask

    // Card sends one frame; reports the block's error pulse and any early drive.
    task automatic card_give(input logic [8:0] bits, output bit nack_seen, output bit early);
        nack_seen = 1'b0; early = 1'b0;
        wait_tick(); card_drive = 1'b1;
        for (int m = 1; m <= 12*OVS + 2; m++) begin
            wait_tick();
            if (m % OVS == 0 && m <= 9*OVS) card_drive = !bits[m/OVS - 1];
            if (m == 10*OVS) card_drive = 1'b0;
            if (m < 10*OVS + OVS/2 && dut_drive) early = 1'b1;
            if (m == 11*OVS) nack_seen = !io_line;
        end
    endtask

    task automatic watch_line(input int n, output bit low);
        low = 1'b0;
        repeat (n) begin
            @(negedge clk);
            if (io_line === 1'b0) low = 1'b1;
        end
    endtask

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [8:0] b, b0;
        bit d11, d12, ns, early, low;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_empty && tx_done && !rx_full, "R1 buffers", {tx_empty, tx_done, rx_full}, 3'b110);
        chk({err_overrun, err_parity, err_nack, err_retry} == 4'b0, "R1 flags",
            {err_overrun, err_parity, err_nack, err_retry}, 0);
        chk(!dut_drive && !card_clk, "R1 line/clock", {dut_drive, card_clk}, 0);

        tx_en = 1'b1; rx_en = 1'b1;
        // R2 direct convention.
        write_byte(8'hA5);
        chk(!tx_empty, "R2 buffer taken", tx_empty, 0);
        card_take(1'b0, b, d11, d12);
        chk(b == exp_line(8'hA5, 0, 0, 0), "R2 direct frame", b, exp_line(8'hA5, 0, 0, 0));
        chk(tx_empty, "R2 buffer freed", tx_empty, 1);
        chk(!d11 && d12, "R7 normal guard", {d11, d12}, 2'b01);
        chk(!rx_full && !err_parity, "R13 no self receive", {rx_full, err_parity}, 0);
        chk(!err_nack, "R5 no nack flag", err_nack, 0);

        // R3 inverse convention.
        cfg_msb_first = 1; cfg_invert = 1;
        write_byte(8'h3B);
        card_take(1'b0, b, d11, d12);
        chk(b == exp_line(8'h3B, 1, 1, 0), "R3 inverse frame", b, exp_line(8'h3B, 1, 1, 0));
        // R4 odd parity, direct order.
        cfg_msb_first = 0; cfg_invert = 0; cfg_odd_par = 1;
        write_byte(8'h0E);
        card_take(1'b0, b, d11, d12);
        chk(b == exp_line(8'h0E, 0, 0, 1), "R4 odd parity frame", b, exp_line(8'h0E, 0, 0, 1));
        cfg_odd_par = 0;

        // R7 shortened guard.
        cfg_gsm = 1;
        write_byte(8'h5C);
        card_take(1'b0, b, d11, d12);
        chk(d11, "R7 gsm guard", d11, 1);
        cfg_gsm = 0;

        // R5 one refusal then acceptance.
        write_byte(8'h96);
        card_take(1'b1, b0, d11, d12);
        card_take(1'b0, b, d11, d12);
        chk(b0 == exp_line(8'h96, 0, 0, 0) && b == b0, "R5 identical resend", b, b0);
        chk(err_nack && !err_retry, "R5 flags", {err_nack, err_retry}, 2'b10);
        chk(!rx_full && !err_parity, "R13 refused frames", {rx_full, err_parity}, 0);
        pulse_clr();
        chk(!err_nack, "R11 flag_clr", err_nack, 0);

        // R6 every attempt refused.
        write_byte(8'h71);
        for (int a = 0; a <= MAXR; a++) begin
            card_take(1'b1, b, d11, d12);
            chk(b == exp_line(8'h71, 0, 0, 0), "R6 attempt frame", b, exp_line(8'h71, 0, 0, 0));
        end
        watch_line(20*OVS*4, low);
        chk(!low, "R6 no further frame", low, 0);
        chk(err_retry && tx_done, "R6 limit flags", {err_retry, tx_done}, 2'b11);
        pulse_clr();

        // R8 good reception, direct.
        card_give(exp_line(8'h5A, 0, 0, 0), ns, early);
        chk(rx_full && rx_byte == 8'h5A, "R8 direct byte", rx_byte, 8'h5A);
        chk(!ns && !early, "R8 no error pulse", {ns, early}, 0);
        // R10 overrun.
        card_give(exp_line(8'h33, 0, 0, 0), ns, early);
        chk(err_overrun && rx_byte == 8'h5A, "R10 overrun", {err_overrun, rx_byte}, {1'b1, 8'h5A});
        pulse_rd();
        chk(!rx_full, "R8 read clears", rx_full, 0);
        // R8 inverse reception.
        cfg_msb_first = 1; cfg_invert = 1;
        card_give(exp_line(8'hC4, 1, 1, 0), ns, early);
        chk(rx_full && rx_byte == 8'hC4, "R8 inverse byte", rx_byte, 8'hC4);
        pulse_rd();
        cfg_msb_first = 0; cfg_invert = 0;

        // R9 bad parity.
        card_give(exp_line(8'h21, 0, 0, 0) ^ 9'h100, ns, early);
        chk(ns && !early, "R9 error pulse window", {ns, early}, 2'b10);
        chk(err_parity && !rx_full, "R9 flags", {err_parity, rx_full}, 2'b10);

        // R11 receiver disabled.
        rx_en = 1'b0;
        card_give(exp_line(8'h21, 0, 0, 0) ^ 9'h100, ns, early);
        chk(!ns && !rx_full, "R11 rx disabled", {ns, rx_full}, 0);
        // R11 transmitter disabled.
        tx_en = 1'b0;
        write_byte(8'hE7);
        watch_line(20*OVS*4, low);
        chk(!low && !tx_empty, "R11 tx held", {low, tx_empty}, 0);
        tx_en = 1'b1;
        card_take(1'b0, b, d11, d12);
        chk(b == exp_line(8'hE7, 0, 0, 0), "R11 tx released", b, exp_line(8'hE7, 0, 0, 0));

        // R12 clock modes (compared every clock by the model).
        cfg_clk_mode = 2'b01; repeat (10) @(negedge clk);
        cfg_gsm = 1; cfg_clk_mode = 2'b11; repeat (4) @(negedge clk);
        chk(card_clk, "R12 gsm hold high", card_clk, 1);
        cfg_clk_mode = 2'b10; repeat (4) @(negedge clk);
        cfg_gsm = 0; cfg_clk_mode = 2'b11; repeat (4) @(negedge clk);
        chk(!card_clk, "R12 illegal mode low", card_clk, 0);
        cfg_clk_mode = 2'b00; repeat (4) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule